// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two IEEE 754 single-precision operands and returns a single-precision product one clock after the operands are presented. The product's magnitude comes from a full 24 × 24 significand multiply. The result needs at most one right shift to be normalised. It is then rounded to nearest, with ties going to even, using guard, round and sticky bits drawn from the discarded low part of the product. The exponent is the sum of the two biased exponents less one bias. The sign is the exclusive OR of the operand signs.

Special encodings are screened before the arithmetic result is used. A NaN operand yields a quiet NaN. Infinity times zero also yields a quiet NaN. Infinity times a nonzero value gives a signed infinity, and zero times a finite value gives a signed zero. Operands with a zero exponent field are treated as zero. When a finite product leaves the normal range, the block returns a signed infinity and raises an overflow flag, or returns a signed zero and raises an underflow flag. It never emits a denormal.

A caller asserts `in_valid` with both operands. The matching result and its `out_valid` strobe appear after the next rising clock edge. While `in_valid` is low, the result registers keep their previous contents.

Top module: `fp32_mul`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low otherwise. `product`, `ovf` and `unf` change only on an edge where `in_valid` is high.
- R2: For every result that is not a NaN, bit 31 of `product` equals the exclusive OR of bit 31 of `a` and bit 31 of `b`.
- R3: For finite nonzero operands, the result's biased exponent (bits 30:23) is the sum of the operand exponent fields minus 127. It is one greater when the significand product is 2 or more, in which case the significand is shifted right by one.
- R4: The 23-bit fraction (bits 22:0) is rounded to nearest, ties to even. The first discarded bit is the guard bit. The next is the round bit. The OR of all lower product bits is the sticky bit. The fraction is incremented when guard is 1 and any of round, sticky or the kept fraction LSB is 1.
- R5: When rounding carries out of the significand, the fraction becomes zero and the exponent rises by one more.
- R6: If the final exponent of a finite product is 255 or more, the output is the infinity of the result sign (exponent field all ones, fraction zero) and `ovf` is 1.
- R7: If the final exponent of a finite product is 0 or less, the output is the zero of the result sign and `unf` is 1. A final exponent of exactly 1 is delivered as a normal number with `unf` at 0.
- R8: If either operand is a NaN (exponent field 255, fraction nonzero), the output is 0x7FC00000 with both flags 0.
- R9: Infinity (exponent field 255, fraction zero) times a zero-class operand gives 0x7FC00000 with both flags 0.
- R10: Infinity times a nonzero finite or infinite operand gives the infinity of the result sign with both flags 0.
- R11: An operand with exponent field 0 (zero or denormal encoding) times a finite operand gives the zero of the result sign with both flags 0.
- R12: While `rst_n` is low, `out_valid`, `product`, `ovf` and `unf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands `a` and `b` are valid this cycle |
| a | input | 32 | First single-precision operand |
| b | input | 32 | Second single-precision operand |
| out_valid | output | 1 | `product` and flags hold a fresh result |
| product | output | 32 | Single-precision product |
| ovf | output | 1 | Finite product exceeded the largest exponent |
| unf | output | 1 | Finite product fell below the smallest normal exponent |

## Verification
Every result is due exactly one rising edge after the edge that captures `in_valid` with its operands. There is no other latency, because the whole datapath sits between the inputs and a single register stage. Each directed scenario applies its operands on a falling edge and lets one rising edge pass. It then reads `product`, the flags and `out_valid` on the following falling edge, before the next capture can disturb them. The hold scenario waits one more edge with `in_valid` low and changed operands. It then confirms that the previous product and flags are still present and that `out_valid` has dropped.

// File: rtl/fp32_mul.sv
module fp32_mul #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [EXP_W+FRAC_W:0]       a,
  input  logic [EXP_W+FRAC_W:0]       b,
  output logic                        out_valid,
  output logic [EXP_W+FRAC_W:0]       product,
  output logic                        ovf,
  output logic                        unf
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XE_W   = EXP_W + 3;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic              sa, sb, sz;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;

  assign sa = a[W-1];
  assign sb = b[W-1];
  assign ea = a[W-2 -: EXP_W];
  assign eb = b[W-2 -: EXP_W];
  assign fa = a[FRAC_W-1:0];
  assign fb = b[FRAC_W-1:0];
  assign sz = sa ^ sb;

  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == EXP_W'(EMAX)) && (fa == '0);
  assign b_inf  = (eb == EXP_W'(EMAX)) && (fb == '0);
  assign a_nan  = (ea == EXP_W'(EMAX)) && (fa != '0);
  assign b_nan  = (eb == EXP_W'(EMAX)) && (fb != '0);

  // significand product, one-step normalisation
  logic [PROD_W-1:0] prod;
  logic              hi;
  logic [PROD_W-2:0] norm;
  assign prod = {1'b1, fa} * {1'b1, fb};
  assign hi   = prod[PROD_W-1];
  assign norm = hi ? prod[PROD_W-2:0] : {prod[PROD_W-3:0], 1'b0};

  // round to nearest even
  logic [FRAC_W-1:0] keep;
  logic              guard_b, round_b, sticky_b, bump;
  logic [FRAC_W:0]   rounded;
  logic              carry;
  assign keep     = norm[PROD_W-2 -: FRAC_W];
  assign guard_b  = norm[PROD_W-2-FRAC_W];
  assign round_b  = norm[PROD_W-3-FRAC_W];
  assign sticky_b = |norm[PROD_W-4-FRAC_W:0];
  assign bump     = guard_b & (round_b | sticky_b | keep[0]);
  assign rounded  = {1'b0, keep} + {{FRAC_W{1'b0}}, bump};
  assign carry    = rounded[FRAC_W];

  // exponent path, two's complement in XE_W bits
  logic [XE_W-1:0] e_fin;
  logic            e_big, e_small;
  assign e_fin   = XE_W'(ea) + XE_W'(eb) - XE_W'(BIAS) + XE_W'(hi) + XE_W'(carry);
  assign e_big   = !e_fin[XE_W-1] && (e_fin >= XE_W'(EMAX));
  assign e_small = e_fin[XE_W-1] || (e_fin == '0);

  logic [W-1:0] res_d;
  logic         ovf_d, unf_d;

  always_comb begin
    res_d = {sz, e_fin[EXP_W-1:0], rounded[FRAC_W-1:0]};
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (a_nan || b_nan) begin
      res_d = QNAN;
    end else if ((a_inf && b_zero) || (b_inf && a_zero)) begin
      res_d = QNAN;
    end else if (a_inf || b_inf) begin
      res_d = {sz, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (a_zero || b_zero) begin
      res_d = {sz, {(W-1){1'b0}}};
    end else if (e_big) begin
      res_d = {sz, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_d = 1'b1;
    end else if (e_small) begin
      res_d = {sz, {(W-1){1'b0}}};
      unf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        product <= res_d;
        ovf     <= ovf_d;
        unf     <= unf_d;
      end
    end
  end
endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] a,
  input logic [EXP_W+FRAC_W:0] b,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] product,
  input logic                  ovf,
  input logic                  unf
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic prod_is_nan;
  assign prod_is_nan = (product[W-2 -: EXP_W] == '1) && (product[FRAC_W-1:0] != '0);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(product) && $stable(ovf) && $stable(unf)));

  // R2
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !prod_is_nan) |-> (product[W-1] == ($past(a[W-1]) ^ $past(b[W-1]))));

  // R6
  ovf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (product[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  // R7
  unf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (product[W-2:0] == '0));

  // R6 R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  // R8
  nan_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a[W-2 -: EXP_W] == '1) && (a[FRAC_W-1:0] != '0))
      |=> (product == QNAN && !ovf && !unf));
endmodule

bind fp32_mul fp32_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .product(product), .ovf(ovf), .unf(unf)
);

// File: tb/fp32_mul_bench.sv
module fp32_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid, ovf, unf;
  logic [31:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp32_mul u_fp32_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .product(product), .ovf(ovf), .unf(unf)
  );

  task automatic check(input string req, input logic [31:0] got_p, input logic got_o,
                       input logic got_u, input logic got_v, input logic [31:0] exp_p,
                       input logic exp_o, input logic exp_u, input logic exp_v);
    checks++;
    if (got_p !== exp_p || got_o !== exp_o || got_u !== exp_u || got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: got product=%h ovf=%b unf=%b valid=%b, expected product=%h ovf=%b unf=%b valid=%b",
               req, got_p, got_o, got_u, got_v, exp_p, exp_o, exp_u, exp_v);
    end
  endtask

  task automatic mul(input string req, input logic [31:0] x, input logic [31:0] y,
                     input logic [31:0] exp_p, input logic exp_o, input logic exp_u);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, product, ovf, unf, out_valid, exp_p, exp_o, exp_u, 1'b1);
  endtask

  task automatic t_reset;
    check("R12", product, ovf, unf, out_valid, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_exponent;
    mul("R3", 32'h3FC00000, 32'h40000000, 32'h40400000, 0, 0);
    mul("R3", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0);
    mul("R3", 32'h3F800000, 32'h3F800000, 32'h3F800000, 0, 0);
  endtask

  task automatic t_sign;
    mul("R2", 32'hC0000000, 32'h40400000, 32'hC0C00000, 0, 0);
    mul("R2", 32'hC0000000, 32'hC0400000, 32'h40C00000, 0, 0);
  endtask

  task automatic t_round;
    mul("R4", 32'h3F800001, 32'h3F800001, 32'h3F800002, 0, 0);
    mul("R4", 32'h3F800800, 32'h3F800800, 32'h3F801000, 0, 0);
    mul("R4", 32'h3F800800, 32'h3F800801, 32'h3F801002, 0, 0);
    mul("R4", 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, 0);
  endtask

  task automatic t_carry;
    mul("R5", 32'h3F800001, 32'h3FFFFFFE, 32'h40000000, 0, 0);
  endtask

  task automatic t_overflow;
    mul("R6", 32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0);
    mul("R6", 32'hFF000000, 32'h40000000, 32'hFF800000, 1, 0);
    mul("R6", 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 0, 0);
  endtask

  task automatic t_underflow;
    mul("R7", 32'h00800000, 32'h3F000000, 32'h00000000, 0, 1);
    mul("R7", 32'h80800000, 32'h3F000000, 32'h80000000, 0, 1);
    mul("R7", 32'h00800000, 32'h3F800000, 32'h00800000, 0, 0);
  endtask

  task automatic t_nan;
    mul("R8", 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 0, 0);
    mul("R8", 32'h3F800000, 32'hFF800001, 32'h7FC00000, 0, 0);
    mul("R8", 32'h7F800005, 32'h7F800000, 32'h7FC00000, 0, 0);
  endtask

  task automatic t_inf_zero;
    mul("R9", 32'h7F800000, 32'h00000000, 32'h7FC00000, 0, 0);
    mul("R9", 32'h80000000, 32'hFF800000, 32'h7FC00000, 0, 0);
    mul("R9", 32'h7F800000, 32'h00000001, 32'h7FC00000, 0, 0);
  endtask

  task automatic t_inf;
    mul("R10", 32'h7F800000, 32'hC0000000, 32'hFF800000, 0, 0);
    mul("R10", 32'hFF800000, 32'hFF800000, 32'h7F800000, 0, 0);
  endtask

  task automatic t_zero;
    mul("R11", 32'h00000000, 32'hC0400000, 32'h80000000, 0, 0);
    mul("R11", 32'h00400000, 32'h40000000, 32'h00000000, 0, 0);
    mul("R11", 32'h80000000, 32'hBF800000, 32'h00000000, 0, 0);
  endtask

  task automatic t_hold;
    mul("R1", 32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0);
    @(negedge clk);
    a = 32'h3F800000; b = 32'h3F800000;
    @(posedge clk);
    @(negedge clk);
    check("R1", product, ovf, unf, out_valid, 32'h7F800000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_exponent();
    t_sign();
    t_round();
    t_carry();
    t_overflow();
    t_underflow();
    t_nan();
    t_inf_zero();
    t_inf();
    t_zero();
    t_hold();
    finish_run();
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      finish_run();
    end
  end
endmodule